// File: doc/BRIEF.md
# Fault Auto-Restart Sequencer

This block decides when the power switches of a resonant converter controller may run. It watches a two-level primary current comparator pair, a status bit that says whether the input voltage lies inside its allowed window, and a supply-good bit from an undervoltage detector. A fault takes the block out of the running state. It then drives a soft-start discharge output and keeps the switches disabled for a cooldown measured in oscillator clocks. After the cooldown it allows a new start. The comparators and the oscillator are outside the block. A one-clock pulse marks the end of each switching cycle.

There are two cooldown lengths. After a power-on reset, or after the supply has dipped and come back, the block uses a short count. This case includes waiting for the input voltage to enter its window for the first time. Every other fault uses a long count. A current fault is raised by either of two tiers. One is a single sample of the high comparator. The other is a run of consecutive switching cycles in which the low comparator fired. The fault status output tells the rest of the chip that a fault cooldown is in progress.

Top module: `restartSequencer`

## Requirements
- R1: While reset is applied and just after it is released, `discharge` is 1, `runEn` is 0 and `faultOut` is 0.
- R2: After reset, the short cooldown starts only once `supplyOk` and `vinOk` are both 1. From that first clear clock, `discharge` stays 1 for exactly SHORT_COOL clocks, and `runEn` becomes 1 on the next clock. `faultOut` stays 0 throughout.
- R3: `runEn` is never 1 on the clock after a clock in which `supplyOk` was 0, and `runEn` and `discharge` are never both 1.
- R4: While running, `vinOk` at 0 for one clock makes `discharge` and `faultOut` 1 on the next clock. A long cooldown follows: `discharge` stays 1 for LONG_COOL clocks after the faults clear.
- R5: While running, a single clock with `csHigh` at 1 triggers the same long-cooldown fault as R4.
- R6: While running, a switching cycle counts as a hit when `csLow` was 1 on any clock of that cycle, up to and including the clock that carries `cycleTick`. TRIP_CYCLES consecutive hits raise a long-cooldown fault on the tick that completes the run. A cycle without a hit clears the run.
- R7: A `csLow` pulse that has ended before the tick of its switching cycle still counts as a hit.
- R8: If `supplyOk` drops, either while running or during a long cooldown, the cooldown that follows its return is the short one (SHORT_COOL clocks), and `faultOut` is 1.
- R9: During a cooldown, any clock with a fault input active (`supplyOk` 0, `vinOk` 0 or `csHigh` 1) restarts the count from zero. The full length is counted again after the last such clock.
- R10: `faultOut` is set by a fault and stays 1 for as long as a fault input persists and until the cooldown expires. It falls in the same clock in which `runEn` rises.
- R11: If `csHigh` is 1 during the first wait after reset, that wait becomes a long cooldown and `faultOut` becomes 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock that paces all counting |
| rstN | input | 1 | Active-low asynchronous power-on reset |
| cycleTick | input | 1 | One-clock pulse marking the end of a switching cycle |
| csLow | input | 1 | Lower current comparator output |
| csHigh | input | 1 | Higher current comparator output (also used for remote-off) |
| vinOk | input | 1 | Input voltage is inside its window (low means brown-out, overvoltage or remote-off) |
| supplyOk | input | 1 | Controller supply is above its undervoltage threshold |
| discharge | output | 1 | Soft-start discharge pull-up enable |
| runEn | output | 1 | Switches may operate |
| faultOut | output | 1 | A fault cooldown is in progress |

## Verification
The hardest case to reach is the consecutive-cycle current trip. It depends on the history of several switching cycles. It also depends on when `csLow` pulses fall inside a cycle, not on a single input value. The bench sweeps every 6-cycle hit pattern from a running state. Each pulse ends before its tick, so only the in-cycle memory can carry it. For each cycle, the bench works out from the run length whether the trip is due, and then checks the long cooldown that follows. Restart-from-zero and the switch to the short count are reached by injecting a fault input part-way through a running long cooldown.

// File: rtl/restartSeqPkg.sv
package restartSeqPkg;

  typedef enum logic {
    ST_COOL = 1'b0,
    ST_RUN  = 1'b1
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic coolClr;    // restart cooldown count from zero
    logic coolInc;    // advance cooldown count by one clock
    logic useShort;   // select short cooldown length
    logic runActive;  // switches running: enable cycle counting
  } ctlStrobes_t;

endpackage

// File: rtl/restartSeqDatapath.sv
module restartSeqDatapath
  import restartSeqPkg::*;
#(
  parameter int LONG_COOL   = 131072,
  parameter int SHORT_COOL  = 1024,
  parameter int TRIP_CYCLES = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t strobes,
  input  logic        cycleTick,
  input  logic        csLow,
  output logic        coolDone,
  output logic        csTrip
);

  localparam int MAX_COOL = (LONG_COOL > SHORT_COOL) ? LONG_COOL : SHORT_COOL;
  localparam int CW = (MAX_COOL > 2) ? $clog2(MAX_COOL) : 1;
  localparam int TW = (TRIP_CYCLES > 1) ? $clog2(TRIP_CYCLES + 1) : 1;
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_COOL - 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_COOL - 1);
  localparam logic [TW-1:0] TRIP_LAST  = TW'(TRIP_CYCLES - 1);

  logic [CW-1:0] coolCnt;
  logic [CW-1:0] coolLast;
  logic [TW-1:0] consecCnt;
  logic          csLowSeen;
  logic          cycleHit;

  // cooldown length select
  generate
    if (LONG_COOL == SHORT_COOL) begin : gSameLen
      assign coolLast = LONG_LAST;
    end else begin : gTwoLen
      assign coolLast = strobes.useShort ? SHORT_LAST : LONG_LAST;
    end
  endgenerate

  assign coolDone = strobes.coolInc && (coolCnt == coolLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coolCnt <= '0;
    end else if (strobes.coolClr) begin
      coolCnt <= '0;
    end else if (strobes.coolInc) begin
      coolCnt <= coolDone ? '0 : coolCnt + 1'b1;
    end
  end

  // hit memory inside one switching cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csLowSeen <= 1'b0;
    end else if (!strobes.runActive || cycleTick) begin
      csLowSeen <= 1'b0;
    end else if (csLow) begin
      csLowSeen <= 1'b1;
    end
  end

  assign cycleHit = csLowSeen || csLow;

  generate
    if (TRIP_CYCLES == 1) begin : gSingleTrip
      assign consecCnt = '0;
      assign csTrip    = strobes.runActive && cycleTick && cycleHit;
    end else begin : gCountTrip
      logic [TW-1:0] consecReg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          consecReg <= '0;
        end else if (!strobes.runActive) begin
          consecReg <= '0;
        end else if (cycleTick) begin
          if (!cycleHit || consecReg == TRIP_LAST) consecReg <= '0;
          else                                      consecReg <= consecReg + 1'b1;
        end
      end
      assign consecCnt = consecReg;
      assign csTrip    = strobes.runActive && cycleTick && cycleHit && (consecReg == TRIP_LAST);
    end
  endgenerate

  // R6
  consec_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    consecCnt <= TRIP_LAST);

  // R9
  cool_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.coolClr |=> (coolCnt == '0));

  // R8
  short_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.useShort |-> (coolCnt <= SHORT_LAST));

endmodule

// File: rtl/restartSeqControl.sv
module restartSeqControl
  import restartSeqPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        supplyOk,
  input  logic        vinOk,
  input  logic        csHigh,
  input  logic        coolDone,
  input  logic        csTrip,
  output ctlStrobes_t strobes,
  output logic        discharge,
  output logic        runEn,
  output logic        faultOut
);

  seqState_t stateQ, stateD;
  logic      shortQ, shortD;
  logic      faultQ, faultD;
  logic      anyHold;

  assign anyHold = !supplyOk || !vinOk || csHigh;

  always_comb begin
    stateD = stateQ;
    shortD = shortQ;
    faultD = faultQ;
    unique case (stateQ)
      ST_RUN: begin
        if (!supplyOk) begin
          stateD = ST_COOL;
          shortD = 1'b1;
          faultD = 1'b1;
        end else if (!vinOk || csHigh || csTrip) begin
          stateD = ST_COOL;
          shortD = 1'b0;
          faultD = 1'b1;
        end
      end
      default: begin
        if (!supplyOk) begin
          shortD = 1'b1;
        end else if (csHigh) begin
          shortD = 1'b0;
          faultD = 1'b1;
        end
        if (!anyHold && coolDone) begin
          stateD = ST_RUN;
          shortD = 1'b0;
          faultD = 1'b0;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_COOL;
      shortQ <= 1'b1;
      faultQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      shortQ <= shortD;
      faultQ <= faultD;
    end
  end

  always_comb begin
    strobes.coolClr   = (stateQ == ST_COOL) && anyHold;
    strobes.coolInc   = (stateQ == ST_COOL) && !anyHold;
    strobes.useShort  = shortQ;
    strobes.runActive = (stateQ == ST_RUN);
  end

  assign runEn     = (stateQ == ST_RUN);
  assign discharge = (stateQ != ST_RUN);
  assign faultOut  = faultQ;

  // R3
  supply_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> !runEn);

  // R4
  vin_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && supplyOk && (!vinOk || csHigh)) |=> (discharge && faultOut && !shortQ));

  // R10
  fault_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(faultOut) |-> runEn);

  // R6
  trip_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csTrip && supplyOk) |=> (discharge && faultOut));

endmodule

// File: rtl/restartSequencer.sv
module restartSequencer
  import restartSeqPkg::*;
#(
  parameter int LONG_COOL   = 131072,
  parameter int SHORT_COOL  = 1024,
  parameter int TRIP_CYCLES = 7
) (
  input  logic clk,
  input  logic rstN,
  input  logic cycleTick,
  input  logic csLow,
  input  logic csHigh,
  input  logic vinOk,
  input  logic supplyOk,
  output logic discharge,
  output logic runEn,
  output logic faultOut
);

  ctlStrobes_t strobes;
  logic        coolDone;
  logic        csTrip;

  restartSeqControl uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .supplyOk (supplyOk),
    .vinOk    (vinOk),
    .csHigh   (csHigh),
    .coolDone (coolDone),
    .csTrip   (csTrip),
    .strobes  (strobes),
    .discharge(discharge),
    .runEn    (runEn),
    .faultOut (faultOut)
  );

  restartSeqDatapath #(
    .LONG_COOL  (LONG_COOL),
    .SHORT_COOL (SHORT_COOL),
    .TRIP_CYCLES(TRIP_CYCLES)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .cycleTick(cycleTick),
    .csLow    (csLow),
    .coolDone (coolDone),
    .csTrip   (csTrip)
  );

  // R3
  exclusive_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(runEn && discharge));

endmodule

// File: tb/tb_restartSequencer.sv
module tb_restartSequencer;

  localparam int CLK_PERIOD = 10;
  localparam int LONG  = 40;
  localparam int SHORT = 8;
  localparam int TRIP  = 3;
  localparam int PAT_LEN = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cycleTick = 1'b0;
  logic csLow = 1'b0;
  logic csHigh = 1'b0;
  logic vinOk = 1'b0;
  logic supplyOk = 1'b0;
  logic discharge, runEn, faultOut;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  restartSequencer #(
    .LONG_COOL  (LONG),
    .SHORT_COOL (SHORT),
    .TRIP_CYCLES(TRIP)
  ) dut (
    .clk      (clk),
    .rstN     (rstN),
    .cycleTick(cycleTick),
    .csLow    (csLow),
    .csHigh   (csHigh),
    .vinOk    (vinOk),
    .supplyOk (supplyOk),
    .discharge(discharge),
    .runEn    (runEn),
    .faultOut (faultOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // counts clocks from now until runEn rises; checks faultOut while waiting
  task automatic measure(input int expLen, input bit expFault, input string tag);
    int k = 0;
    bit faultBad = 1'b0;
    while (k < 200) begin
      @(negedge clk);
      k++;
      if (runEn) break;
      if (faultOut !== expFault) faultBad = 1'b1;
    end
    check(k == expLen, {tag, " cooldown length"}, k, expLen);
    check(!faultBad, {tag, " R10 faultOut during cooldown"}, faultBad ? !expFault : expFault, expFault);
    check(faultOut == 1'b0 && discharge == 1'b0, {tag, " R10 faultOut cleared at run"}, faultOut, 0);
  endtask

  task automatic doCycle(input bit hit);
    @(negedge clk);
    csLow = hit;
    @(negedge clk);
    csLow = 1'b0;
    cycleTick = 1'b1;
    @(negedge clk);
    cycleTick = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    @(negedge clk);
    check(discharge && !runEn && !faultOut, "R1 in reset", {discharge, runEn, faultOut}, 3'b100);
    doReset();
    @(negedge clk);
    check(discharge && !runEn && !faultOut, "R1 after reset", {discharge, runEn, faultOut}, 3'b100);

    // R2 short first start, input enters window late
    supplyOk = 1'b1;
    repeat (20) @(negedge clk);
    check(!runEn, "R2 waits for brown-in", runEn, 0);
    vinOk = 1'b1;
    measure(SHORT, 1'b0, "R2 first start");

    // R4 vin low one clock while running
    vinOk = 1'b0;
    @(negedge clk);
    vinOk = 1'b1;
    check(discharge && faultOut, "R4 vin fault reaction", {discharge, faultOut}, 2'b11);
    measure(LONG, 1'b1, "R4 long cooldown");

    // R5 single csHigh pulse
    csHigh = 1'b1;
    @(negedge clk);
    csHigh = 1'b0;
    check(discharge && faultOut, "R5 single pulse reaction", {discharge, faultOut}, 2'b11);
    measure(LONG, 1'b1, "R5 long cooldown");

    // R9 fault during cooldown restarts count
    csHigh = 1'b1;
    @(negedge clk);
    csHigh = 1'b0;
    repeat (15) @(negedge clk);
    vinOk = 1'b0;
    @(negedge clk);
    vinOk = 1'b1;
    measure(LONG, 1'b1, "R9 restart count");

    // R10 persistent fault keeps discharge beyond the long count
    csHigh = 1'b1;
    repeat (LONG + 30) @(negedge clk);
    check(discharge && faultOut && !runEn, "R10 held by persistent fault", {discharge, faultOut, runEn}, 3'b110);
    csHigh = 1'b0;
    measure(LONG, 1'b1, "R10 after release");

    // R8 supply dip during a long cooldown
    csHigh = 1'b1;
    @(negedge clk);
    csHigh = 1'b0;
    repeat (10) @(negedge clk);
    supplyOk = 1'b0;
    repeat (5) begin
      @(negedge clk);
      check(!runEn, "R3 no run with supply low", runEn, 0);
    end
    supplyOk = 1'b1;
    measure(SHORT, 1'b1, "R8 dip in cooldown");

    // R8 supply dip while running
    supplyOk = 1'b0;
    @(negedge clk);
    check(discharge && faultOut && !runEn, "R8 supply drop reaction", {discharge, faultOut, runEn}, 3'b110);
    repeat (4) @(negedge clk);
    supplyOk = 1'b1;
    measure(SHORT, 1'b1, "R8 dip while running");

    // R6 R7 sweep over all hit patterns of PAT_LEN cycles
    for (int p = 0; p < (1 << PAT_LEN); p++) begin
      int run = 0;
      bit tripped = 1'b0;
      for (int i = 0; i < PAT_LEN && !tripped; i++) begin
        bit b = p[i];
        doCycle(b);
        run = b ? run + 1 : 0;
        if (run == TRIP) tripped = 1'b1;
        check(runEn == !tripped, $sformatf("R6 R7 pattern %0d cycle %0d", p, i), runEn, !tripped);
      end
      if (tripped) begin
        check(faultOut == 1'b1, $sformatf("R6 trip fault pattern %0d", p), faultOut, 1);
        measure(LONG, 1'b1, "R6 trip cooldown");
      end else begin
        doCycle(1'b0);
      end
    end

    // R11 csHigh during first wait after reset
    doReset();
    vinOk = 1'b1;
    supplyOk = 1'b1;
    @(negedge clk);
    csHigh = 1'b1;
    @(negedge clk);
    csHigh = 1'b0;
    check(faultOut && discharge, "R11 fault in first wait", {faultOut, discharge}, 2'b11);
    measure(LONG, 1'b1, "R11 long first wait");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule